// File: doc/BRIEF.md
# Shuffle-Exchange Route Stepper

This block plans and walks a path through a shuffle-exchange interconnect with a power-of-two number of nodes. Each node has two outgoing links. The shuffle link leads to the node whose address is the current address rotated left by one bit. The exchange link leads to the node whose address has its lowest bit inverted.

A start pulse loads a source and a destination address. The block then emits one link choice per clock cycle and reports the node reached after each hop. When the current node equals the destination, it raises a single-cycle done flag.

The route is built one destination bit at a time, beginning with the most significant bit. Round 0 consists only of an exchange decision. Each later round starts with a shuffle and is followed by an exchange decision. An exchange is taken only when the current bit 0 disagrees with the destination bit for that round. The walk stops as soon as the destination is reached, so unneeded exchanges and trailing rotations are never issued.

The block carries no packets and resolves no contention. It only produces the address sequence.

Top module: `sx_route_planner`

## Requirements
- R1: While reset is asserted, hop_valid and done are 0 and cur_addr is 0.
- R2: A hop with hop_link = 0 is a shuffle. In that cycle cur_addr is the previous cur_addr rotated left by one bit, with the top bit moving into bit 0.
- R3: A hop with hop_link = 1 is an exchange. In that cycle cur_addr is the previous cur_addr with bit 0 inverted.
- R4: In the cycle after the last hop, done is 1 for exactly one cycle, and cur_addr equals the destination. This holds for every source and destination pair at 8 and 16 nodes.
- R5: A route never takes more than 2·log2(NODES) − 1 hops. Routing from address 0 to the all-ones address takes exactly that number.
- R6: When source equals destination, done rises on the second clock edge after the start edge, and no hop is emitted.
- R7: A start pulse that arrives while a route is active is ignored. The route continues to its original destination with its original hop count.
- R8: When start is accepted, cur_addr shows the source in the next cycle. From the following cycle on, every cycle carries either a hop or done until done occurs.
- R9: Round i (i from 0) compares bit 0 against destination bit log2(NODES)−1−i. An exchange is taken only on a mismatch, and every round except round 0 begins with a shuffle. As a result, 16-node routes 0→1, 1→0, 5→10 and 8→1 take 4, 1, 1 and 1 hops.
- R10: hop_valid and done are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a route; accepted only when idle |
| src_addr | input | log2(NODES) | Source node address |
| dst_addr | input | log2(NODES) | Destination node address |
| hop_valid | output | 1 | A hop was taken this cycle |
| hop_link | output | 1 | 0 = shuffle, 1 = exchange |
| cur_addr | output | log2(NODES) | Node currently occupied by the route |
| done | output | 1 | Single-cycle pulse: destination reached |

## Verification
The hardest case to produce from the ports is a start pulse that lands in the middle of a route. It has to arrive after hops have begun but before done. To reach it, the bench launches the worst-case 0→all-ones route, counts two hops, and then drives a second start with a different source and destination. It then checks that the original route finishes unchanged. Completion at the destination is also checked exhaustively for every pair at 8 and 16 nodes, and each hop's address is compared against the link it claims.

// File: rtl/sx_route_pkg.sv
package sx_route_pkg;
   typedef enum logic {
      LINK_SHUF = 1'b0,
      LINK_EXCH = 1'b1
   } link_e;
endpackage

// File: rtl/sx_rotl.sv
// Rotate a W-bit word left by one position (pure wiring).
module sx_rotl #(
   parameter int W = 4
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (i == 0) begin : g_wrap
            assign dout[0] = din[W-1];
         end else begin : g_shift
            assign dout[i] = din[i-1];
         end
      end
   endgenerate
endmodule

// File: rtl/sx_hop_select.sv
// Chooses the next hop from the present node, the destination and the round.
module sx_hop_select #(
   parameter int K  = 4,
   parameter int RW = 2
) (
   input  logic [K-1:0]  cur,
   input  logic [K-1:0]  dst,
   input  logic [RW-1:0] round,
   input  logic          xphase,
   output logic          at_dst,
   output logic          take_exch,
   output logic [K-1:0]  next_addr
);
   localparam int SLOTS = 1 << RW;

   logic [K-1:0]     rotated;
   logic [SLOTS-1:0] want;

   sx_rotl #(.W(K)) u_rot (
      .din  (cur),
      .dout (rotated)
   );

   // Destination bits in consumption order: round i wants bit K-1-i.
   generate
      for (genvar i = 0; i < SLOTS; i++) begin : g_want
         if (i < K) begin : g_live
            assign want[i] = dst[K-1-i];
         end else begin : g_pad
            assign want[i] = 1'b0;
         end
      end
   endgenerate

   assign at_dst    = (cur == dst);
   assign take_exch = xphase && (cur[0] != want[round]);
   assign next_addr = take_exch ? {cur[K-1:1], ~cur[0]} : rotated;
endmodule

// File: rtl/sx_route_planner.sv
module sx_route_planner
   import sx_route_pkg::*;
#(
   parameter int NODES = 16,
   localparam int K    = $clog2(NODES),
   localparam int RW   = $clog2(K)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [K-1:0] src_addr,
   input  logic [K-1:0] dst_addr,
   output logic         hop_valid,
   output logic         hop_link,
   output logic [K-1:0] cur_addr,
   output logic         done
);
   generate
      if (NODES < 4 || (NODES & (NODES - 1)) != 0) begin : g_bad_nodes
         $error("sx_route_planner: NODES must be a power of two, at least 4");
      end
   endgenerate

   logic          busy_q;
   logic [K-1:0]  cur_q;
   logic [K-1:0]  dst_q;
   logic [RW-1:0] round_q;
   logic          xphase_q;
   link_e         link_q;
   logic          valid_q;
   logic          done_q;

   logic          at_dst;
   logic          take_exch;
   logic [K-1:0]  next_addr;

   sx_hop_select #(.K(K), .RW(RW)) u_sel (
      .cur       (cur_q),
      .dst       (dst_q),
      .round     (round_q),
      .xphase    (xphase_q),
      .at_dst    (at_dst),
      .take_exch (take_exch),
      .next_addr (next_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         cur_q    <= '0;
         dst_q    <= '0;
         round_q  <= '0;
         xphase_q <= 1'b0;
         link_q   <= LINK_SHUF;
         valid_q  <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         done_q  <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               busy_q   <= 1'b1;
               cur_q    <= src_addr;
               dst_q    <= dst_addr;
               round_q  <= '0;
               xphase_q <= 1'b1;
            end
         end else if (at_dst) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else begin
            valid_q <= 1'b1;
            cur_q   <= next_addr;
            if (take_exch) begin
               link_q   <= LINK_EXCH;
               xphase_q <= 1'b0;
            end else begin
               link_q   <= LINK_SHUF;
               xphase_q <= 1'b1;
               round_q  <= round_q + RW'(1);
            end
         end
      end
   end

   assign hop_valid = valid_q;
   assign hop_link  = link_q;
   assign cur_addr  = cur_q;
   assign done      = done_q;
endmodule

// File: rtl/sx_route_checker.sv
module sx_route_checker #(
   parameter int K = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic         hop_valid,
   input logic         hop_link,
   input logic [K-1:0] cur_addr,
   input logic         done
);
   localparam int MAXH = 2 * K - 1;

   logic [K+1:0] hops_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hops_q <= '0;
      else if (done)      hops_q <= '0;
      else if (hop_valid) hops_q <= hops_q + 1'b1;
   end

   assert_shuffle_rot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hop_valid && !hop_link) |->
         cur_addr == {$past(cur_addr[K-2:0]), $past(cur_addr[K-1])});

   assert_exchange_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hop_valid && hop_link) |-> cur_addr == ($past(cur_addr) ^ K'(1)));

   assert_done_holds_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $stable(cur_addr));

   assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_hop_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hop_valid |-> int'(hops_q) < MAXH);

   assert_valid_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(hop_valid && done));
endmodule

bind sx_route_planner sx_route_checker #(.K(K)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hop_valid (hop_valid),
   .hop_link  (hop_link),
   .cur_addr  (cur_addr),
   .done      (done)
);

// File: tb/tb_sx_route_planner.sv
`timescale 1ns/1ps
module tb_sx_route_planner;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   // 16-node instance
   logic       st16 = 1'b0;
   logic [3:0] s16 = '0, d16 = '0;
   logic       v16, l16, dn16;
   logic [3:0] a16;
   // 8-node instance
   logic       st8 = 1'b0;
   logic [2:0] s8 = '0, d8 = '0;
   logic       v8, l8, dn8;
   logic [2:0] a8;

   sx_route_planner #(.NODES(16)) dut (
      .clk(clk), .rst_n(rst_n), .start(st16), .src_addr(s16), .dst_addr(d16),
      .hop_valid(v16), .hop_link(l16), .cur_addr(a16), .done(dn16));
   sx_route_planner #(.NODES(8)) dut8 (
      .clk(clk), .rst_n(rst_n), .start(st8), .src_addr(s8), .dst_addr(d8),
      .hop_valid(v8), .hop_link(l8), .cur_addr(a8), .done(dn8));

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int selk = 4;

   // {src, dst, expected hops} at 16 nodes
   localparam logic [11:0] VEC [6] = '{
      {4'd0, 4'd0,  4'd0},
      {4'd0, 4'd15, 4'd7},
      {4'd0, 4'd1,  4'd4},
      {4'd1, 4'd0,  4'd1},
      {4'd5, 4'd10, 4'd1},
      {4'd8, 4'd1,  4'd1}
   };

   function automatic logic        bv(); return (selk == 3) ? v8  : v16;  endfunction
   function automatic logic        bl(); return (selk == 3) ? l8  : l16;  endfunction
   function automatic logic        bd(); return (selk == 3) ? dn8 : dn16; endfunction
   function automatic logic [3:0]  ba(); return (selk == 3) ? {1'b0, a8} : a16; endfunction

   function automatic logic [3:0] rotl(input logic [3:0] a, input int k);
      if (k == 4) return {a[2:0], a[3]};
      return {1'b0, a[1:0], a[2]};
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_start(input int k, input logic [3:0] s, input logic [3:0] d);
      @(negedge clk);
      if (k == 3) begin st8 = 1'b1; s8 = s[2:0]; d8 = d[2:0]; end
      else        begin st16 = 1'b1; s16 = s; d16 = d; end
      @(negedge clk);
      st8 = 1'b0; st16 = 1'b0;
   endtask

   // Walks a whole route; exp_hops < 0 means "not tabulated".
   task automatic run_route(input int k, input logic [3:0] s, input logic [3:0] d,
                            input int exp_hops);
      logic [3:0] prev;
      int hops;
      bit fin;
      selk = k;
      pulse_start(k, s, d);
      check(ba() == s, "R8 source shown", ba(), s);
      prev = s; hops = 0; fin = 0;
      for (int t = 0; t < 2 * k + 2 && !fin; t++) begin
         @(negedge clk);
         check(!(bv() && bd()), "R10 valid with done", 1, 0);
         if (bv()) begin
            hops++;
            if (bl()) check(ba() == (prev ^ 4'd1), "R3 exchange addr", ba(), prev ^ 4'd1);
            else      check(ba() == rotl(prev, k), "R2 shuffle addr", ba(), rotl(prev, k));
            prev = ba();
         end else if (bd()) begin
            fin = 1;
         end else begin
            check(0, "R8 idle gap", 0, 1);
         end
      end
      check(fin, "R4 done seen", fin, 1);
      check(ba() == d, "R4 final addr", ba(), d);
      check(hops <= 2 * k - 1, "R5 hop bound", hops, 2 * k - 1);
      if (exp_hops >= 0) check(hops == exp_hops, "R9 hop count", hops, exp_hops);
      @(negedge clk);
      check(!bd(), "R4 done single pulse", bd(), 0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      int h;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!v16 && !dn16 && a16 == 0, "R1 reset 16", {v16, dn16, a16}, 0);
      check(!v8 && !dn8 && a8 == 0, "R1 reset 8", {v8, dn8, a8}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 R9 tabulated vectors
      for (int i = 0; i < 6; i++)
         run_route(4, VEC[i][11:8], VEC[i][7:4], int'(VEC[i][3:0]));

      // R6 zero-hop timing: done at second edge after the start edge
      selk = 4;
      pulse_start(4, 4'd9, 4'd9);
      check(!v16 && !dn16, "R6 nothing at first edge", dn16, 0);
      @(negedge clk);
      check(dn16 && !v16, "R6 done at second edge", dn16, 1);
      check(a16 == 4'd9, "R6 addr", a16, 9);

      // R7 start during an active route is ignored
      selk = 4;
      pulse_start(4, 4'd0, 4'd15);
      @(negedge clk); @(negedge clk);
      check(v16, "R7 route active", v16, 1);
      st16 = 1'b1; s16 = 4'd5; d16 = 4'd3;
      @(negedge clk);
      st16 = 1'b0;
      h = 3;
      for (int t = 0; t < 12 && !dn16; t++) begin
         @(negedge clk);
         if (v16) h++;
      end
      check(dn16, "R7 done", dn16, 1);
      check(a16 == 4'd15, "R7 original dst", a16, 15);
      check(h == 7, "R7 original hop count", h, 7);
      @(negedge clk);

      // R4 exhaustive at 8 and 16 nodes
      for (int s = 0; s < 8; s++)
         for (int d = 0; d < 8; d++)
            run_route(3, 4'(s), 4'(d), (s == 0 && d == 7) ? 5 : -1);
      for (int s = 0; s < 16; s++)
         for (int d = 0; d < 16; d++)
            run_route(4, 4'(s), 4'(d), -1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule